// File: doc/BRIEF.md
# I2C Target Interface with SCL-Low Timeout

This block is the target (slave) side of a two-wire I2C bus for a small register-mapped peripheral. It oversamples the open-drain SCL and SDA lines with the system clock. Each line passes through a two-flop synchroniser and a run-length glitch filter. START and STOP are detected on the filtered lines. After START it takes in an address byte. If the address matches, it either takes in data bytes or shifts register contents out. It drives acknowledge bits through an active-low drive enable on SDA.

On a write, the first data byte sets an internal register pointer. Each later byte is written through a byte-wide strobe port at the pointer, and the pointer then advances, wrapping at the register count. On a read, bytes are fetched at the pointer and sent MSB first. The controller's acknowledge decides whether another byte follows.

A watchdog counts system clocks while the filtered SCL is low. When the count reaches a parameterised threshold, the interface drops back to idle, releases SDA and ignores the bus until the next START.

Top module: `i2c_tgt_top`

## Requirements
- R1: START (SDA falling while SCL is high) begins address reception from any state. STOP (SDA rising while SCL is high) returns the block to idle with SDA released.
- R2: Only the first byte `{ADDR, rw}`, with `ADDR` in bits 7:1, is acknowledged (SDA low in the ninth clock). A non-matching address gets no acknowledge, and SDA stays released until the next START.
- R3: In a write (rw = 0), the first data byte, taken modulo `NUM_REGS`, loads the register pointer and is acknowledged without a register write.
- R4: Each later write byte gives exactly one single-cycle `reg_we_o` pulse at the current pointer and is acknowledged. The pointer then advances by one and wraps from `NUM_REGS-1` to 0.
- R5: In a read (rw = 1), the register at the pointer is sent MSB first, with a `reg_re_o` pulse when the byte is fetched. The pointer advances after each byte sent, with the same wrap as R4.
- R6: If the controller does not acknowledge a read byte, the block stops sending and keeps SDA released until STOP or START.
- R7: A repeated START without a preceding STOP restarts address reception and keeps the register pointer.
- R8: When filtered SCL stays low for `TMO_CYCLES` system clocks, the block goes idle, releases SDA and ignores bus traffic until a new START.
- R9: The SDA drive enable changes only while filtered SCL is low, except when START, STOP or a timeout forces a release.
- R10: A pulse on SCL or SDA shorter than `FILT_LEN` system clocks has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_we_o | output | 1 | Register write strobe, one cycle |
| reg_re_o | output | 1 | Register fetch strobe, one cycle |
| reg_addr_o | output | $clog2(NUM_REGS) | Register pointer |
| reg_wdata_o | output | 8 | Write data, valid with reg_we_o |
| reg_rdata_i | input | 8 | Register data at reg_addr_o |

## Verification
The main path is tried with a table of pointer and data pairs. Each pair is written and then read back through a repeated START. The pointers are chosen so that each kind of pointer handling shows up on its own: an ordinary pointer, a pointer that wraps from the last register to 0, and an out-of-range pointer that must be reduced modulo the register count. Data bytes of all ones, all zeros and alternating bits show whether the bits are sent MSB first and whether SDA is driven in the right phase. Directed patterns then check that a wrong address, a controller NACK, a held-low SCL and short glitches on both lines leave the register port and the SDA line untouched.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_filt.sv
module i2c_tgt_filt #(
  parameter int FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic          s1, s2;
  logic [CW-1:0] run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1     <= 1'b1;
      s2     <= 1'b1;
      run    <= '0;
      line_o <= 1'b1;
    end else begin
      s1 <= line_i;
      s2 <= s1;
      if (s2 == line_o) begin
        run <= '0;
      end else if (run == CW'(FILT_LEN - 1)) begin
        run    <= '0;
        line_o <= s2;
      end else begin
        run <= run + 1'b1;
      end
    end
  end

  // the output only moves to a level the synchronised input has been showing
  a_r10_filt_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o != $past(line_o)) |-> ($past(s2) == line_o));
endmodule

// File: rtl/i2c_tgt_wdog.sv
module i2c_tgt_wdog #(
  parameter int TMO_CYCLES = 3_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  output logic tmo_o
);
  localparam int CW = $clog2(TMO_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt <= '0;
    else if (scl_i)                   cnt <= '0;
    else if (cnt != CW'(TMO_CYCLES))  cnt <= cnt + 1'b1;
  end

  // fires once per low period, then the counter saturates
  assign tmo_o = !scl_i && (cnt == CW'(TMO_CYCLES - 1));

  a_r8_tmo_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |=> !tmo_o);
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] ADDR     = 7'h3A,
  parameter int         NUM_REGS = 16,
  localparam int        PW       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              tmo_i,
  output logic              sda_oe_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic [PW-1:0]     reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  tgt_state_e        state;
  logic              scl_q, sda_q;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] sh, tx;
  logic [PW-1:0]     ptr, ptr_nxt;
  logic              rw_q, ptr_ld, inc_q, ack_q;
  logic              start, stop, scl_rise, scl_fall;

  assign start    = scl_i && scl_q && sda_q && !sda_i;
  assign stop     = scl_i && scl_q && !sda_q && sda_i;
  assign scl_rise = scl_i && !scl_q;
  assign scl_fall = !scl_i && scl_q;
  assign ptr_nxt  = (ptr == PW'(NUM_REGS - 1)) ? '0 : ptr + 1'b1;

  assign reg_addr_o  = ptr;
  assign reg_wdata_o = sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      sh       <= '0;
      tx       <= '0;
      ptr      <= '0;
      rw_q     <= 1'b0;
      ptr_ld   <= 1'b0;
      inc_q    <= 1'b0;
      ack_q    <= 1'b0;
      sda_oe_o <= 1'b0;
      reg_we_o <= 1'b0;
      reg_re_o <= 1'b0;
    end else begin
      reg_we_o <= 1'b0;
      reg_re_o <= 1'b0;
      if (tmo_i || stop) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              sh      <= {sh[BYTE_W-2:0], sda_i};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (state == ST_ADDR) begin
                if (sh[7:1] == ADDR) begin
                  sda_oe_o <= 1'b1;
                  rw_q     <= sh[0];
                  ptr_ld   <= !sh[0];
                  state    <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_oe_o <= 1'b1;
                state    <= ST_WR_ACK;
                if (ptr_ld) begin
                  ptr    <= PW'(sh % NUM_REGS);
                  ptr_ld <= 1'b0;
                  inc_q  <= 1'b0;
                end else begin
                  reg_we_o <= 1'b1;
                  inc_q    <= 1'b1;
                end
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rw_q) begin
                tx       <= reg_rdata_i;
                reg_re_o <= 1'b1;
                sda_oe_o <= !reg_rdata_i[7];
                state    <= ST_RD;
              end else begin
                sda_oe_o <= 1'b0;
                state    <= ST_WR;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe_o <= 1'b0;
              bit_cnt  <= '0;
              state    <= ST_WR;
              if (inc_q) ptr <= ptr_nxt;
              inc_q <= 1'b0;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd7) begin
                sda_oe_o <= 1'b0;
                ptr      <= ptr_nxt;
                state    <= ST_RD_ACK;
              end else begin
                tx       <= {tx[BYTE_W-2:0], 1'b0};
                sda_oe_o <= !tx[6];
                bit_cnt  <= bit_cnt + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              ack_q <= !sda_i;
            end else if (scl_fall) begin
              if (ack_q) begin
                tx       <= reg_rdata_i;
                reg_re_o <= 1'b1;
                sda_oe_o <= !reg_rdata_i[7];
                bit_cnt  <= '0;
                state    <= ST_RD;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r1_stop_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> (state == ST_IDLE && !sda_oe_o));

  a_r2_no_ack_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_ADDR && scl_fall && bit_cnt == 4'd8 && sh[7:1] != ADDR && !tmo_i)
    |=> !sda_oe_o);

  a_r4_we_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  a_r6_nack_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RD_ACK && scl_fall && !ack_q && !tmo_i)
    |=> (state == ST_IDLE && !sda_oe_o));

  a_r8_tmo_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_i |=> (state == ST_IDLE && !sda_oe_o));

  a_r9_sda_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && scl_q && !start && !stop && !tmo_i) |=> $stable(sda_oe_o));
endmodule

// File: rtl/i2c_tgt_top.sv
module i2c_tgt_top
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] ADDR       = 7'h3A,
  parameter int         NUM_REGS   = 16,
  parameter int         FILT_LEN   = 3,
  parameter int         TMO_CYCLES = 3_500_000,
  localparam int        PW         = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic [PW-1:0]     reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  logic [1:0] raw, filt;
  logic       tmo;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_tgt_filt #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw[g]),
      .line_o (filt[g])
    );
  end

  i2c_tgt_wdog #(.TMO_CYCLES(TMO_CYCLES)) u_wdog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (filt[1]),
    .tmo_o  (tmo)
  );

  i2c_tgt_fsm #(.ADDR(ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_i       (filt[1]),
    .sda_i       (filt[0]),
    .tmo_i       (tmo),
    .sda_oe_o    (sda_oe_o),
    .reg_we_o    (reg_we_o),
    .reg_re_o    (reg_re_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_rdata_i (reg_rdata_i)
  );
endmodule

// File: tb/i2c_tgt_top_tb.sv
module i2c_tgt_top_tb;
  localparam logic [6:0] ADDR = 7'h3A;
  localparam int NREG = 16;
  localparam int TMO  = 300;
  localparam int Q    = 20;

  // {pointer, first byte, second byte}
  localparam logic [23:0] VEC [5] = '{
    24'h00_11_22, 24'h0F_A5_5A, 24'h13_C3_3C, 24'h07_FF_00, 24'h0A_80_01
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_oe, we, re;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  logic [7:0] mem [NREG];
  int         we_cnt = 0;
  int         n_chk = 0, n_fail = 0;
  logic       gl_scl = 1'b0, gl_sda = 1'b0, done = 1'b0;
  wire        sda_w = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_tgt_top #(.ADDR(ADDR), .NUM_REGS(NREG), .FILT_LEN(3), .TMO_CYCLES(TMO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_w), .sda_oe_o(sda_oe),
    .reg_we_o(we), .reg_re_o(re), .reg_addr_o(addr), .reg_wdata_o(wdata),
    .reg_rdata_i(rdata)
  );

  assign rdata = mem[addr];

  initial for (int i = 0; i < NREG; i++) mem[i] = 8'(8'hE0 + i);

  always @(posedge clk) if (we) begin
    mem[addr] <= wdata;
    we_cnt    <= we_cnt + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic bus_bit(input logic b, output logic r);
    wq(Q); sda_m = b; wq(Q); scl_m = 1'b1; wq(Q/2);
    if (gl_scl) begin scl_m = 1'b0; wq(2); scl_m = 1'b1; end
    if (gl_sda) begin sda_m = ~b; wq(2); sda_m = b; end
    wq(Q/2); r = sda_w; wq(Q); scl_m = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(d[i], r);
    bus_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin bus_bit(1'b1, r); d[i] = r; end
    bus_bit(~mack, r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic a0, a1, a2, a3, a4;
    logic [7:0] d0, d1;
    int  wc;
    wq(4);
    chk("R1 reset sda_oe", sda_oe, 0);
    chk("R4 reset we", we, 0);
    chk("R5 reset re", re, 0);
    rst_n = 1'b1;
    wq(10);

    // vector walk: write pair, read back via repeated start (R3 R4 R5 R7 R9)
    foreach (VEC[v]) begin
      logic [3:0] p0, p1;
      p0 = 4'(VEC[v][23:16] % NREG);
      p1 = p0 + 4'd1;
      wc = we_cnt;
      bus_start();
      wr_byte({ADDR, 1'b0}, a0); wr_byte(VEC[v][23:16], a1);
      wr_byte(VEC[v][15:8], a2); wr_byte(VEC[v][7:0], a3);
      bus_stop();
      wq(2);
      chk("R2 R3 R4 acks", {a0, a1, a2, a3}, 4'hF);
      chk("R4 write count", we_cnt - wc, 2);
      chk("R1 released after stop", sda_oe, 0);
      chk("R4 reg at ptr", mem[p0], VEC[v][15:8]);
      chk("R4 reg at wrapped ptr+1", mem[p1], VEC[v][7:0]);
      bus_start();
      wr_byte({ADDR, 1'b0}, a0); wr_byte(VEC[v][23:16], a1);
      bus_start();
      wr_byte({ADDR, 1'b1}, a2);
      rd_byte(1'b1, d0); rd_byte(1'b0, d1);
      bus_stop();
      chk("R7 acks around repeated start", {a0, a1, a2}, 3'h7);
      chk("R5 R9 read first", d0, VEC[v][15:8]);
      chk("R5 read second wrapped", d1, VEC[v][7:0]);
    end

    // R2: wrong address gets no ack and following bytes are ignored
    wc = we_cnt;
    bus_start();
    wr_byte({ADDR ^ 7'h01, 1'b0}, a0); wr_byte(8'h02, a1); wr_byte(8'h99, a2);
    bus_stop();
    chk("R2 mismatch no ack", {a0, a1, a2}, 3'h0);
    chk("R2 mismatch no write", we_cnt - wc, 0);

    // R6: controller NACK releases SDA; reg 4 holds 3C from vector 2
    bus_start();
    wr_byte({ADDR, 1'b0}, a0); wr_byte(8'h04, a1);
    bus_start();
    wr_byte({ADDR, 1'b1}, a2);
    rd_byte(1'b0, d0); rd_byte(1'b1, d1);
    bus_stop();
    chk("R6 first byte", d0, 8'h3C);
    chk("R6 released after nack", d1, 8'hFF);

    // R8: hold SCL low past the threshold mid-write
    wc = we_cnt;
    bus_start();
    wr_byte({ADDR, 1'b0}, a0); wr_byte(8'h05, a1);
    wq(TMO + 100);
    wr_byte(8'h77, a2); wr_byte(8'h66, a3);
    chk("R8 ignored after timeout", {a0, a1, a2, a3}, 4'hC);
    chk("R8 no write after timeout", we_cnt - wc, 0);
    chk("R8 reg untouched", mem[5], 8'hE5);
    bus_stop();
    bus_start();
    wr_byte({ADDR, 1'b0}, a4);
    bus_stop();
    chk("R8 recovers on start", a4, 1);

    // R10: short glitches on both lines during the data byte
    bus_start();
    wr_byte({ADDR, 1'b0}, a0); wr_byte(8'h09, a1);
    gl_scl = 1'b1; gl_sda = 1'b1;
    wr_byte(8'h5C, a2);
    gl_scl = 1'b0; gl_sda = 1'b0;
    bus_stop();
    wq(2);
    chk("R10 acks with glitches", {a0, a1, a2}, 3'h7);
    chk("R10 glitch-free write", mem[9], 8'h5C);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule